// File: doc/BRIEF.md
# Comparator Deglitch and Converter Latch-Off Controller

This block turns the digital result of an external threshold comparator into a filtered output level for a power-conversion controller. The raw result is first synchronized into the clock domain. A polarity control selects whether "input above threshold" or "input below threshold" pulls the output low. A falling output is accepted only after the low condition has persisted for one of four selectable time windows, counted in ticks of a free-running timebase. A rising output passes through without any filtering delay.

When the force-off enable is set, a filtered low output latches a converter shutdown. While the latch is set, the charger-ok indicator is deasserted and the charge-current request seen by the converter is overridden to zero. The requested value itself is passed in unchanged, so nothing needs to be restored when the latch clears. The latch is released in two ordered steps. First the output returns high while the enable is still set. Then the enable is cleared. The reference-select field is only carried through to the analog side.

Top module: `cmp_guard_ctrl`

## Requirements
- R1: With `pol_i`=0 the low condition is `cmp_raw_i`=1 (input above threshold). With `pol_i`=1 the low condition is `cmp_raw_i`=0.
- R2: When the raw input leaves the low condition, `cmp_out_o` returns high on the third rising clock edge, with no deglitch delay. This covers two synchronizer stages and one output register.
- R3: `cmp_out_o` falls only after the low condition has been present for N consecutive tick cycles. N is selected by `dg_sel_i`: 00 gives DG_T0, 01 gives DG_T1, 10 gives DG_T2 and 11 gives DG_T3. The defaults are 5, 2000, 20000 and 5000000 ticks of 1 µs. With a tick on every cycle, the output falls on clock edge N+2 after the raw input changes.
- R4: If the low condition drops before N ticks have been counted, the count restarts from zero. Cycles without a tick do not advance the count.
- R5: With `force_en_i`=1 and `cmp_out_o` low, `conv_off_o` becomes 1 and `chrg_ok_o` becomes 0 on the next clock edge.
- R6: While `conv_off_o`=1, `ichg_eff_o`=0 and `ichg_zero_o`=1. Otherwise `ichg_eff_o` equals `ichg_req_i` and `ichg_zero_o`=0.
- R7: The latch clears only after `cmp_out_o` has been seen high while `force_en_i`=1, and `force_en_i` has then been set to 0. If `force_en_i` is cleared while the output is still low, the latch holds.
- R8: After reset, `cmp_out_o`=1, `conv_off_o`=0 and `chrg_ok_o`=1. `ref_sel_o` always equals `ref_sel_i`.
- R9: With `force_en_i`=0, a low output never sets the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel_i | input | 1 | Comparator reference select (0: higher reference) |
| pol_i | input | 1 | Output polarity select |
| dg_sel_i | input | 2 | Falling-edge deglitch window select |
| force_en_i | input | 1 | Enable converter latch-off |
| tick_i | input | 1 | One-cycle pulse from the 1 µs timebase |
| cmp_raw_i | input | 1 | Asynchronous comparator result, 1 = above threshold |
| ichg_req_i | input | ICHG_W | Programmed charge-current value |
| cmp_out_o | output | 1 | Filtered comparator output level |
| conv_off_o | output | 1 | Converter latched off |
| chrg_ok_o | output | 1 | Charger-ok indicator |
| ichg_zero_o | output | 1 | Charge-current zero override active |
| ichg_eff_o | output | ICHG_W | Effective charge current |
| ref_sel_o | output | 1 | Reference select passed to the comparator |

## Verification
The bench sweeps all four window selects under both polarities, with windows shrunk to a few ticks. It measures the exact edge on which the output falls and rises, which separates a one-off window length from a polarity swap or an unfiltered rising edge. Low pulses one tick shorter than the window and exactly as long as it show where the filter threshold lies. Two short pulses separated by one idle cycle show whether the count restarts, and a run with the timebase stopped shows whether the count advances only on ticks. Latch sequences release in the correct order, release in the wrong order, and run with the enable off, which tells the two-step release apart from a plain level clear.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;

    typedef enum logic [1:0] {
        DG_SHORT = 2'b00,
        DG_MID   = 2'b01,
        DG_LONG  = 2'b10,
        DG_XLONG = 2'b11
    } dg_sel_e;

    typedef struct packed {
        logic out_hi;
        logic low_req;
    } cmp_state_t;

    typedef struct packed {
        logic conv_off;
        logic chrg_ok;
        logic ichg_zero;
    } latch_state_t;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/cmpg_sync.sv
module cmpg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= 1'b0;
                    else     pipe[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= 1'b0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cmpg_deglitch.sv
module cmpg_deglitch
    import cmpg_pkg::*;
#(
    parameter int unsigned CNT_W  = 23,
    parameter int unsigned DG_T0  = 5,
    parameter int unsigned DG_T1  = 2000,
    parameter int unsigned DG_T2  = 20000,
    parameter int unsigned DG_T3  = 5000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       above_i,
    input  logic       pol_i,
    input  dg_sel_e    sel_i,
    input  logic       tick_i,
    output cmp_state_t st_o
);
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;
    logic             low_req;
    logic             out_hi;

    always_comb begin
        unique case (sel_i)
            DG_SHORT: lim = CNT_W'(DG_T0);
            DG_MID:   lim = CNT_W'(DG_T1);
            DG_LONG:  lim = CNT_W'(DG_T2);
            default:  lim = CNT_W'(DG_T3);
        endcase
    end

    // Polarity 0: above threshold pulls the output low; polarity 1: below does.
    assign low_req = pol_i ? ~above_i : above_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            out_hi <= 1'b1;
        end else if (!low_req) begin
            cnt    <= '0;
            out_hi <= 1'b1;
        end else if (!out_hi) begin
            cnt    <= '0;
        end else if (tick_i) begin
            if (cnt >= lim - 1'b1) begin
                cnt    <= '0;
                out_hi <= 1'b0;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end

    assign st_o.out_hi  = out_hi;
    assign st_o.low_req = low_req;

    // R2: leaving the low condition brings the output high on the next edge
    a_r2_rise_undelayed: assert property (@(posedge clk) disable iff (rst)
        !low_req |=> out_hi);

    // R3: a fall requires the low condition and a tick in the previous cycle
    a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        (out_hi && !$past(rst)) ##1 !out_hi |-> $past(low_req) && $past(tick_i));

    // R4: without a tick the output cannot fall
    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (out_hi && !tick_i) |=> out_hi);
endmodule

// File: rtl/cmpg_latch.sv
module cmpg_latch
    import cmpg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         out_hi_i,
    input  logic         force_en_i,
    output latch_state_t st_o
);
    logic off_q;
    logic rel_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q    <= 1'b0;
            rel_ok_q <= 1'b0;
        end else begin
            if (force_en_i && !out_hi_i) begin
                off_q    <= 1'b1;
                rel_ok_q <= 1'b0;
            end else if (off_q) begin
                if (rel_ok_q && !force_en_i) begin
                    off_q    <= 1'b0;
                    rel_ok_q <= 1'b0;
                end else if (!out_hi_i) begin
                    rel_ok_q <= 1'b0;
                end else if (force_en_i) begin
                    rel_ok_q <= 1'b1;
                end
            end
        end
    end

    assign st_o.conv_off  = off_q;
    assign st_o.chrg_ok   = ~off_q;
    assign st_o.ichg_zero = off_q;

    // R5: enable plus low output sets the latch one edge later
    a_r5_latch_sets: assert property (@(posedge clk) disable iff (rst)
        (force_en_i && !out_hi_i) |=> off_q);

    // R7: the latch never clears while the enable is still set
    a_r7_hold_while_enabled: assert property (@(posedge clk) disable iff (rst)
        (off_q && force_en_i) |=> off_q);

    // R7: clearing happens only with the enable low in the previous cycle
    a_r7_clear_needs_disable: assert property (@(posedge clk) disable iff (rst)
        $fell(off_q) |-> !$past(force_en_i));

    // R9: with the enable off, a latch that is clear stays clear
    a_r9_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        (!off_q && !force_en_i) |=> !off_q);
endmodule

// File: rtl/cmp_guard_ctrl.sv
module cmp_guard_ctrl
    import cmpg_pkg::*;
#(
    parameter int unsigned ICHG_W      = 13,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DG_T0       = 5,
    parameter int unsigned DG_T1       = 2000,
    parameter int unsigned DG_T2       = 20000,
    parameter int unsigned DG_T3       = 5000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_sel_i,
    input  logic              pol_i,
    input  logic [1:0]        dg_sel_i,
    input  logic              force_en_i,
    input  logic              tick_i,
    input  logic              cmp_raw_i,
    input  logic [ICHG_W-1:0] ichg_req_i,
    output logic              cmp_out_o,
    output logic              conv_off_o,
    output logic              chrg_ok_o,
    output logic              ichg_zero_o,
    output logic [ICHG_W-1:0] ichg_eff_o,
    output logic              ref_sel_o
);
    localparam int unsigned DG_MAX = max_of4(DG_T0, DG_T1, DG_T2, DG_T3);
    localparam int unsigned CNT_W  = cnt_width(DG_MAX);

    logic         above_s;
    cmp_state_t   cst;
    latch_state_t lst;

    cmpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_raw_i),
        .q_o (above_s)
    );

    cmpg_deglitch #(
        .CNT_W (CNT_W),
        .DG_T0 (DG_T0),
        .DG_T1 (DG_T1),
        .DG_T2 (DG_T2),
        .DG_T3 (DG_T3)
    ) u_dg (
        .clk     (clk),
        .rst     (rst),
        .above_i (above_s),
        .pol_i   (pol_i),
        .sel_i   (dg_sel_e'(dg_sel_i)),
        .tick_i  (tick_i),
        .st_o    (cst)
    );

    cmpg_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .out_hi_i   (cst.out_hi),
        .force_en_i (force_en_i),
        .st_o       (lst)
    );

    assign cmp_out_o   = cst.out_hi;
    assign conv_off_o  = lst.conv_off;
    assign chrg_ok_o   = lst.chrg_ok;
    assign ichg_zero_o = lst.ichg_zero;
    assign ichg_eff_o  = lst.ichg_zero ? '0 : ichg_req_i;
    assign ref_sel_o   = ref_sel_i;

    // R6: the converter never sees a nonzero current while latched off
    a_r6_zero_when_off: assert property (@(posedge clk) disable iff (rst)
        conv_off_o |-> (ichg_eff_o == '0) && !chrg_ok_o);

    // R8: indicator and latch are always complementary
    a_r8_ok_consistent: assert property (@(posedge clk) disable iff (rst)
        chrg_ok_o != conv_off_o);
endmodule

// File: tb/test_cmp_guard_ctrl.sv
`timescale 1ns/1ps
module test_cmp_guard_ctrl;
    localparam int unsigned W  = 13;
    localparam int unsigned T0 = 3;
    localparam int unsigned T1 = 5;
    localparam int unsigned T2 = 8;
    localparam int unsigned T3 = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_sel = 1'b0;
    logic         pol = 1'b0;
    logic [1:0]   dg_sel = 2'b00;
    logic         force_en = 1'b0;
    logic         tick = 1'b1;
    logic         raw = 1'b0;
    logic [W-1:0] ichg_req = 13'h0A5;
    logic         cmp_out, conv_off, chrg_ok, ichg_zero, ref_out;
    logic [W-1:0] ichg_eff;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_guard_ctrl #(
        .ICHG_W (W), .SYNC_STAGES (2),
        .DG_T0 (T0), .DG_T1 (T1), .DG_T2 (T2), .DG_T3 (T3)
    ) i_cmp_guard_ctrl (
        .clk (clk), .rst (rst), .ref_sel_i (ref_sel), .pol_i (pol),
        .dg_sel_i (dg_sel), .force_en_i (force_en), .tick_i (tick),
        .cmp_raw_i (raw), .ichg_req_i (ichg_req), .cmp_out_o (cmp_out),
        .conv_off_o (conv_off), .chrg_ok_o (chrg_ok), .ichg_zero_o (ichg_zero),
        .ichg_eff_o (ichg_eff), .ref_sel_o (ref_out)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b00:   return T0;
            2'b01:   return T1;
            2'b10:   return T2;
            default: return T3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // raw value that makes the low condition true for the current polarity (R1)
    function automatic logic low_val();
        return pol ? 1'b0 : 1'b1;
    endfunction

    task automatic idle();
        raw = ~low_val();
        repeat (6) @(negedge clk);
    endtask

    task automatic fall_rise(input logic [1:0] s, input logic p);
        int n;
        @(negedge clk);
        dg_sel = s;
        pol = p;
        idle();
        raw = low_val();
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (!cmp_out) break;
        end
        check(n == lim_of(s) + 2, "R3/R1 fall edge", n, lim_of(s) + 2);
        @(negedge clk);
        check(conv_off == 1'b0, "R9 no latch when disabled", conv_off, 0);
        raw = ~low_val();
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (cmp_out) break;
        end
        check(n == 3, "R2 rise edge", n, 3);
    endtask

    task automatic pulse(input logic [1:0] s, input int w, input int gap, input int w2);
        bit seen_low;
        int L;
        L = lim_of(s);
        @(negedge clk);
        dg_sel = s;
        idle();
        seen_low = 1'b0;
        raw = low_val();
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (!cmp_out) seen_low = 1'b1;
        end
        raw = ~low_val();
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (!cmp_out) seen_low = 1'b1;
        end
        if (w2 > 0) begin
            raw = low_val();
            for (int i = 0; i < w2; i++) begin
                @(negedge clk);
                if (!cmp_out) seen_low = 1'b1;
            end
            raw = ~low_val();
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!cmp_out) seen_low = 1'b1;
        end
        if (w2 > 0)
            check(seen_low == 1'b0, "R4 restart after gap", seen_low, 0);
        else
            check(seen_low == (w >= L), "R3 pulse threshold", seen_low, (w >= L));
    endtask

    task automatic force_low();
        raw = low_val();
        repeat (lim_of(dg_sel) + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(cmp_out == 1'b1, "R8 reset out", cmp_out, 1);
        check(conv_off == 1'b0, "R8 reset latch", conv_off, 0);
        check(chrg_ok == 1'b1, "R8 reset ok", chrg_ok, 1);
        rst = 1'b0;
        ref_sel = 1'b1;
        @(negedge clk);
        check(ref_out == 1'b1, "R8 ref pass", ref_out, 1);
        check(ichg_eff == ichg_req, "R6 eff when unlatched", ichg_eff, ichg_req);

        // R1 R2 R3 R9 sweep
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 4; s++)
                fall_rise(2'(s), 1'(p));

        // R3 threshold pulses, R4 restart
        pol = 1'b0;
        for (int s = 0; s < 4; s++) begin
            pulse(2'(s), lim_of(2'(s)) - 1, 0, 0);
            pulse(2'(s), lim_of(2'(s)), 0, 0);
            pulse(2'(s), lim_of(2'(s)) - 1, 1, lim_of(2'(s)) - 1);
        end

        // R4 no tick, no progress
        @(negedge clk);
        dg_sel = 2'b00;
        idle();
        tick = 1'b0;
        raw = low_val();
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (!cmp_out) seen = 1'b1;
            end
            check(seen == 1'b0, "R4 no tick hold", seen, 0);
        end
        tick = 1'b1;
        idle();

        // R5 R6 R7 ordered release
        force_en = 1'b1;
        ichg_req = 13'h1F3;
        force_low();
        check(conv_off == 1'b1, "R5 latch set", conv_off, 1);
        check(chrg_ok == 1'b0, "R5 ok low", chrg_ok, 0);
        check(ichg_eff == 0 && ichg_zero == 1'b1, "R6 zero override", ichg_eff, 0);
        raw = ~low_val();
        repeat (6) @(negedge clk);
        check(conv_off == 1'b1, "R7 hold after out high", conv_off, 1);
        force_en = 1'b0;
        @(negedge clk);
        check(conv_off == 1'b0, "R7 clear after disable", conv_off, 0);
        check(ichg_eff == ichg_req, "R6 value restored", ichg_eff, ichg_req);

        // R7 wrong order: disable while output low
        force_en = 1'b1;
        force_low();
        check(conv_off == 1'b1, "R5 latch set again", conv_off, 1);
        force_en = 1'b0;
        repeat (3) @(negedge clk);
        check(conv_off == 1'b1, "R7 hold when disabled early", conv_off, 1);
        raw = ~low_val();
        repeat (6) @(negedge clk);
        check(conv_off == 1'b1, "R7 hold after late release", conv_off, 1);
        force_en = 1'b1;
        repeat (2) @(negedge clk);
        force_en = 1'b0;
        repeat (2) @(negedge clk);
        check(conv_off == 1'b0, "R7 clear after re-sequence", conv_off, 0);
        check(chrg_ok == 1'b1, "R7 ok restored", chrg_ok, 1);

        // R9 low output with enable off
        force_low();
        check(cmp_out == 1'b0 && conv_off == 1'b0, "R9 no latch", conv_off, 0);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule